// File: doc/BRIEF.md
# Eight-Channel Flag Interrupt Hub

This block collects the flag outputs of eight counting channels into one interrupt line. Each channel delivers two active-low flag pins. A two-bit source code per channel tells the hub what those pins currently carry, so the hub can decide which pin transitions count as an interrupt event. An event is the rising edge of the decoded event condition. It latches a sticky pending bit, but only for channels whose enable bit is set.

Software works through a byte-wide register bus at fixed offsets. It can read the pending bits, write the operation register, program the per-channel enables, read the raw index input levels, and program and read cable supervision. The operation register holds two controls: a global counter reset, driven out as a pin, and the global interrupt-function enable that gates the interrupt output. Any write to the operation register clears every pending bit. Cable supervision uses active-low logic in both directions. Writing a 0 enables checking for a channel, and a 0 read back means a fault on a channel that is being checked.

Top module: `chan_irq_hub`

## Requirements
- R1: After reset, every pending bit, every channel enable, operation bit 0 (counter reset) and operation bit 2 (interrupt function) are 0, all cable-check enables at offset 0x17 are 1 (checking off), and `irq` is low.
- R2: Each channel's source code sits at bits [2c+1:2c] of `flg_src`. Code 0 (carry and borrow) treats either flag pin low as the event. Codes 1 (compare), 2 (combined carry/borrow) and 3 (index pulse) treat only a low first flag pin (`flg1_n[c]`) as the event; the second pin has no effect in those codes.
- R3: A channel's pending bit is set in the clock edge at which its event condition goes from inactive to active. It then stays set until it is cleared. An event condition that is held active does not set the bit again after a clear.
- R4: An event sets pending bit c only while bit c of the enable register at offset 0x12 is 1. The enable register is readable and writable.
- R5: Any write to offset 0x11 clears all pending bits. A channel whose event edge falls in the same cycle as that write still ends up pending.
- R6: `irq` is high exactly when bit 2 of the operation register is 1 and at least one pending bit is set.
- R7: Bit 0 of the operation register drives `cnt_reset` (1 = hold all counters in reset, 0 = let them count). A read of 0x11 returns bits 0 and 2 as written and 0 elsewhere.
- R8: A read of offset 0x10 returns the pending bits, with channel c at bit c.
- R9: A read of offset 0x16 returns `index_lvl` with channel c at bit c.
- R10: Offset 0x17 stores the active-low cable-check enables. A read returns, for bit c, 0 when checking is enabled (stored bit 0) and `cable_fault[c]` is 1; in every other case it returns 1.
- R11: Reads at offsets other than 0x10, 0x11, 0x12, 0x16 and 0x17 return 0. Writes to 0x10 and 0x16 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 5 | Register byte offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| flg1_n | input | 8 | First flag pin of each channel, active low |
| flg2_n | input | 8 | Second flag pin of each channel, active low |
| flg_src | input | 16 | Two-bit flag source code per channel |
| index_lvl | input | 8 | Raw index input level per channel |
| cable_fault | input | 8 | Raw cable fault detection per channel, active high |
| cnt_reset | output | 1 | Global counter reset from operation bit 0 |
| irq | output | 1 | Interrupt request |

## Verification
The bench drives the second flag pin in each source code. A hub that ignored the source code would either miss overflow events in code 0 or raise spurious interrupts on direction and error levels in the other codes. It holds a flag low across a clear, which catches level-sensitive latching. It also lines up an event edge with the clearing write, which catches a clear that silently drops that event. It writes to the read-only offsets and reads unmapped ones to expose decode holes, and it uses a fault on a channel whose checking is disabled to catch a cable status that ignores the enable polarity.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;

  localparam int unsigned ADDR_W = 5;
  localparam int unsigned BYTE_W = 8;

  localparam logic [ADDR_W-1:0] OFS_PEND  = 5'h10;
  localparam logic [ADDR_W-1:0] OFS_OPER  = 5'h11;
  localparam logic [ADDR_W-1:0] OFS_IEN   = 5'h12;
  localparam logic [ADDR_W-1:0] OFS_INDEX = 5'h16;
  localparam logic [ADDR_W-1:0] OFS_CABLE = 5'h17;

  localparam int unsigned OP_RST_BIT = 0;
  localparam int unsigned OP_GIE_BIT = 2;

  typedef enum logic [1:0] {
    SRC_OVF  = 2'd0,
    SRC_CMP  = 2'd1,
    SRC_CYBW = 2'd2,
    SRC_IDX  = 2'd3
  } flag_src_e;

  // Event condition decoded from the two active-low flag pins.
  function automatic logic flag_event(flag_src_e src, logic f1_n, logic f2_n);
    logic ev;
    case (src)
      SRC_OVF: ev = !f1_n || !f2_n;
      default: ev = !f1_n;
    endcase
    return ev;
  endfunction

  // Active-low cable status: 0 only for an enabled, faulted channel.
  function automatic logic [BYTE_W-1:0] cable_status(logic [BYTE_W-1:0] en_n,
                                                     logic [BYTE_W-1:0] fault);
    return ~(~en_n & fault);
  endfunction

endpackage

// File: rtl/irq_hub_chan.sv
module irq_hub_chan
  import irq_hub_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       flg1_n,
  input  logic       flg2_n,
  input  logic [1:0] src,
  input  logic       en,
  input  logic       clr,
  output logic       evt_rise,
  output logic       pend
);

  logic evt;
  logic evt_q;
  logic pend_q;

  assign evt      = flag_event(flag_src_e'(src), flg1_n, flg2_n);
  assign evt_rise = evt && !evt_q;
  assign pend     = pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      evt_q <= evt;
      if (evt_rise && en)
        pend_q <= 1'b1;
      else if (clr)
        pend_q <= 1'b0;
    end
  end

  // R4: a new pending bit needs the enable in the cycle it was set
  a_r4_set_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> $past(en));

  // R3: pending holds until a clear
  a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !clr) |=> pend);

  // R5: a clear with no new edge empties the bit
  a_r5_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !evt_rise) |=> !pend);

endmodule

// File: rtl/irq_hub_regs.sv
module irq_hub_regs
  import irq_hub_pkg::*;
#(
  parameter int unsigned NCH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [NCH-1:0]    pend,
  input  logic [NCH-1:0]    idx_lvl,
  input  logic [NCH-1:0]    cbl_fault,
  output logic [BYTE_W-1:0] rdata,
  output logic [NCH-1:0]    ien,
  output logic              op_rst,
  output logic              op_gie,
  output logic              clr_all
);

  logic [NCH-1:0] ien_q;
  logic [NCH-1:0] cbl_en_n_q;
  logic           op_rst_q;
  logic           op_gie_q;

  logic [BYTE_W-1:0] pend_b, idx_b, fault_b, en_n_b, ien_b, oper_b;

  assign clr_all = wr && (addr == OFS_OPER);
  assign ien     = ien_q;
  assign op_rst  = op_rst_q;
  assign op_gie  = op_gie_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q      <= '0;
      cbl_en_n_q <= '1;
      op_rst_q   <= 1'b0;
      op_gie_q   <= 1'b0;
    end else if (wr) begin
      case (addr)
        OFS_OPER: begin
          op_rst_q <= wdata[OP_RST_BIT];
          op_gie_q <= wdata[OP_GIE_BIT];
        end
        OFS_IEN:   ien_q      <= wdata[NCH-1:0];
        OFS_CABLE: cbl_en_n_q <= wdata[NCH-1:0];
        default: ;
      endcase
    end
  end

  // Widen channel vectors to a byte; unused upper channels read as absent.
  always_comb begin
    pend_b  = '0;
    idx_b   = '0;
    fault_b = '0;
    en_n_b  = '1;
    ien_b   = '0;
    oper_b  = '0;
    pend_b[NCH-1:0]  = pend;
    idx_b[NCH-1:0]   = idx_lvl;
    fault_b[NCH-1:0] = cbl_fault;
    en_n_b[NCH-1:0]  = cbl_en_n_q;
    ien_b[NCH-1:0]   = ien_q;
    oper_b[OP_RST_BIT] = op_rst_q;
    oper_b[OP_GIE_BIT] = op_gie_q;
  end

  always_comb begin
    case (addr)
      OFS_PEND:  rdata = pend_b;
      OFS_OPER:  rdata = oper_b;
      OFS_IEN:   rdata = ien_b;
      OFS_INDEX: rdata = idx_b;
      OFS_CABLE: rdata = cable_status(en_n_b, fault_b);
      default:   rdata = '0;
    endcase
  end

  // R11: writes to read-only offsets leave the stored controls alone
  a_r11_ro_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && (addr == OFS_PEND || addr == OFS_INDEX))
      |=> ($stable(ien_q) && $stable(cbl_en_n_q) && $stable(op_rst_q) && $stable(op_gie_q)));

  // R11: unmapped reads return 0
  a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (addr != OFS_PEND && addr != OFS_OPER && addr != OFS_IEN &&
     addr != OFS_INDEX && addr != OFS_CABLE) |-> (rdata == '0));

  // R7: a write to the operation register lands in the next cycle
  a_r7_oper_write: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> (op_rst_q == $past(wdata[OP_RST_BIT]) && op_gie_q == $past(wdata[OP_GIE_BIT])));

endmodule

// File: rtl/chan_irq_hub.sv
module chan_irq_hub
  import irq_hub_pkg::*;
#(
  parameter int unsigned NCH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic [NCH-1:0]    flg1_n,
  input  logic [NCH-1:0]    flg2_n,
  input  logic [2*NCH-1:0]  flg_src,
  input  logic [NCH-1:0]    index_lvl,
  input  logic [NCH-1:0]    cable_fault,
  output logic              cnt_reset,
  output logic              irq
);

  localparam int unsigned SRC_W = 2;

  logic [NCH-1:0] pend_vec;
  logic [NCH-1:0] rise_vec;
  logic [NCH-1:0] ien;
  logic           op_gie;
  logic           clr_all;

  irq_hub_regs #(.NCH(NCH)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (bus_addr),
    .wr        (bus_wr),
    .wdata     (bus_wdata),
    .pend      (pend_vec),
    .idx_lvl   (index_lvl),
    .cbl_fault (cable_fault),
    .rdata     (bus_rdata),
    .ien       (ien),
    .op_rst    (cnt_reset),
    .op_gie    (op_gie),
    .clr_all   (clr_all)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    irq_hub_chan u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .flg1_n   (flg1_n[c]),
      .flg2_n   (flg2_n[c]),
      .src      (flg_src[SRC_W*c +: SRC_W]),
      .en       (ien[c]),
      .clr      (clr_all),
      .evt_rise (rise_vec[c]),
      .pend     (pend_vec[c])
    );
  end

  assign irq = op_gie && (|pend_vec);

  // R5: a clearing write with no enabled edge leaves the line low afterwards
  a_r5_clear_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_all && !(|(rise_vec & ien))) |=> !irq);

  // R6: the interrupt never rises while the function is off
  a_r6_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> op_gie);

  // R4: a disabled channel never contributes a new pending bit
  a_r4_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == '0 && !irq && !clr_all) |=> $stable(pend_vec));

endmodule

// File: tb/tb_chan_irq_hub.sv
module tb_chan_irq_hub;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  bus_addr = 5'h1F;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [7:0]  flg1_n = 8'hFF;
  logic [7:0]  flg2_n = 8'hFF;
  logic [15:0] flg_src;
  logic [7:0]  index_lvl = 8'h00;
  logic [7:0]  cable_fault = 8'h00;
  logic        cnt_reset;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  chan_irq_hub dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .flg1_n(flg1_n),
    .flg2_n(flg2_n), .flg_src(flg_src), .index_lvl(index_lvl),
    .cable_fault(cable_fault), .cnt_reset(cnt_reset), .irq(irq)
  );

  // Channel source codes: ch0 1, ch1 1, ch2 0, ch3 1, ch4 2, ch5 3, ch6 0, ch7 0
  initial flg_src = {2'd0, 2'd0, 2'd3, 2'd2, 2'd1, 2'd0, 2'd1, 2'd1};

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(logic [4:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 5'h1F;
  endtask

  task automatic rd_reg(logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #2 d = bus_rdata;
  endtask

  task automatic pulse1(int c);
    @(negedge clk); flg1_n[c] = 1'b0;
    @(negedge clk); flg1_n[c] = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse2(int c);
    @(negedge clk); flg2_n[c] = 1'b0;
    @(negedge clk); flg2_n[c] = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    cable_fault = 8'hFF;
    rd_reg(5'h10, v); chk("R1 pending", v, 8'h00);
    rd_reg(5'h12, v); chk("R1 enables", v, 8'h00);
    rd_reg(5'h11, v); chk("R1 oper", v, 8'h00);
    rd_reg(5'h17, v); chk("R1 cable disabled", v, 8'hFF);
    chk("R1 irq", irq, 1'b0);
    chk("R1 cnt_reset", cnt_reset, 1'b0);
    cable_fault = 8'h00;
  endtask

  task automatic t_edge_sticky();
    logic [7:0] v;
    wr_reg(5'h11, 8'h04);
    wr_reg(5'h12, 8'h01);
    pulse1(0);
    rd_reg(5'h10, v); chk("R3 pending after pulse", v, 8'h01);
    chk("R6 irq with gie", irq, 1'b1);
    repeat (3) @(negedge clk);
    rd_reg(5'h10, v); chk("R3 sticky", v, 8'h01);
    @(negedge clk); flg1_n[0] = 1'b0;
    wr_reg(5'h11, 8'h04);
    repeat (2) @(negedge clk);
    rd_reg(5'h10, v); chk("R3 held level no re-set", v, 8'h00);
    chk("R5 irq low after clear", irq, 1'b0);
    flg1_n[0] = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_enable_gate();
    logic [7:0] v;
    wr_reg(5'h12, 8'h01);
    pulse1(1);
    rd_reg(5'h10, v); chk("R4 disabled channel", v, 8'h00);
    wr_reg(5'h12, 8'h03);
    rd_reg(5'h12, v); chk("R4 enable readback", v, 8'h03);
    rd_reg(5'h10, v); chk("R4 no late set", v, 8'h00);
    pulse1(1);
    rd_reg(5'h10, v); chk("R4 enabled channel", v, 8'h02);
    wr_reg(5'h11, 8'h04);
  endtask

  task automatic t_map_modes();
    logic [7:0] v;
    wr_reg(5'h12, 8'hFF);
    wr_reg(5'h11, 8'h04);
    pulse2(2);
    rd_reg(5'h10, v); chk("R2 code0 second pin", v, 8'h04);
    pulse2(3); pulse2(4); pulse2(5);
    rd_reg(5'h10, v); chk("R2 codes1-3 ignore second pin", v, 8'h04);
    pulse1(3); pulse1(4); pulse1(5);
    rd_reg(5'h10, v); chk("R2 codes1-3 first pin", v, 8'h3C);
    pulse1(6);
    rd_reg(5'h10, v); chk("R8 pending map", v, 8'h7C);
    wr_reg(5'h11, 8'h04);
    rd_reg(5'h10, v); chk("R5 write clears all", v, 8'h00);
  endtask

  task automatic t_clear_race();
    logic [7:0] v;
    pulse1(0);
    @(negedge clk);
    bus_addr = 5'h11; bus_wdata = 8'h04; bus_wr = 1'b1; flg1_n[7] = 1'b0;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 5'h1F; flg1_n[7] = 1'b1;
    rd_reg(5'h10, v); chk("R5 same-cycle edge kept", v, 8'h80);
    wr_reg(5'h11, 8'h00);
    pulse1(0);
    chk("R6 irq off without gie", irq, 1'b0);
    rd_reg(5'h10, v); chk("R6 pending still set", v, 8'h01);
    wr_reg(5'h11, 8'h04);
  endtask

  task automatic t_oper();
    logic [7:0] v;
    wr_reg(5'h11, 8'hFF);
    rd_reg(5'h11, v); chk("R7 oper readback", v, 8'h05);
    chk("R7 cnt_reset set", cnt_reset, 1'b1);
    wr_reg(5'h11, 8'h04);
    chk("R7 cnt_reset clear", cnt_reset, 1'b0);
  endtask

  task automatic t_index();
    logic [7:0] v;
    index_lvl = 8'hA5;
    rd_reg(5'h16, v); chk("R9 index A5", v, 8'hA5);
    index_lvl = 8'h3C;
    rd_reg(5'h16, v); chk("R9 index 3C", v, 8'h3C);
  endtask

  task automatic t_cable();
    logic [7:0] v;
    wr_reg(5'h17, 8'hF5);
    cable_fault = 8'h0C;
    rd_reg(5'h17, v); chk("R10 cable status", v, 8'hF7);
    cable_fault = 8'h00;
    rd_reg(5'h17, v); chk("R10 no fault", v, 8'hFF);
  endtask

  task automatic t_unmapped();
    logic [7:0] v;
    rd_reg(5'h13, v); chk("R11 read 0x13", v, 8'h00);
    rd_reg(5'h05, v); chk("R11 read 0x05", v, 8'h00);
    wr_reg(5'h12, 8'h01);
    pulse1(0);
    wr_reg(5'h10, 8'hFF);
    wr_reg(5'h16, 8'hFF);
    rd_reg(5'h10, v); chk("R11 pending untouched", v, 8'h01);
    rd_reg(5'h12, v); chk("R11 enables untouched", v, 8'h01);
    rd_reg(5'h11, v); chk("R11 oper untouched", v, 8'h04);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_edge_sticky();
    t_enable_gate();
    t_map_modes();
    t_clear_race();
    t_oper();
    t_index();
    t_cable();
    t_unmapped();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule